// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the data-path unit that combines the accumulator with one second operand. A 4-bit operation code, taken from the high nibble of the instruction, picks the function. The function is one of: increment, decrement, add, add with carry, OR, AND, XOR, subtract with borrow, compare-not-equal, or decrement-for-loop. Operand fetch and write-back are done by neighbouring logic. This unit returns a result byte with its own write strobe. It also returns a next value and an update strobe for each of four status bits: carry, half carry, signed overflow and parity.

All outputs are registered. The caller raises `issue_i` for one cycle with the operation code, the accumulator, the operand and the current carry. One clock edge later every output reflects that operation. In any cycle that follows an edge with `issue_i` low, all strobes are low. The data outputs keep their last value.

Only add, add-with-carry and subtract-with-borrow touch the status bits, and they update all four. The compare updates carry alone and writes no result. The loop decrement writes its result and raises a branch strobe when the new value is non-zero. The datapath width is a parameter. The half carry is taken at the boundary between the lower and upper halves of the word.

Top module: `alu_acc_core`

## Requirements
- R1: Code 0x2 (add) yields acc+opnd and code 0x3 (add with carry) yields acc+opnd+cy_i, both modulo 2^W. Each raises res_we_o, and cy_o is the unsigned carry out of the top bit.
- R2: For codes 0x2/0x3, ac_o is the carry out of bit W/2-1 into bit W/2 (bit 3 into bit 4 at W=8), and ac_we_o is raised.
- R3: For codes 0x2/0x3, ov_o is 1 exactly when the sum of the two signed operands plus carry-in lies outside the signed W-bit range, and ov_we_o is raised.
- R4: Code 0x9 (subtract with borrow) yields acc-opnd-cy_i modulo 2^W. cy_o is 1 when that unsigned difference is negative. ac_o is 1 when the low half minus the operand's low half minus cy_i is negative. ov_o is 1 when the signed difference is out of range. res_we_o, cy_we_o, ac_we_o and ov_we_o are all raised.
- R5: For codes 0x2, 0x3 and 0x9, par_we_o is raised and par_o is the XOR of all result bits. No other code raises par_we_o.
- R6: Code 0x0 yields opnd+1 and code 0x1 yields opnd-1, both wrapping modulo 2^W. Each raises res_we_o and no flag strobe.
- R7: Codes 0x4, 0x5 and 0x6 yield acc OR opnd, acc AND opnd and acc XOR opnd. Each raises res_we_o and no flag strobe, and cy_i has no effect on them.
- R8: Code 0xB (compare) raises no result strobe. It raises cy_we_o only, with cy_o = 1 when acc < opnd unsigned. neq_o is 1 exactly when acc differs from opnd, and cy_i has no effect.
- R9: Code 0xD (loop decrement) yields opnd-1 with res_we_o raised and no flag strobe. jump_o is 1 exactly when that result is non-zero.
- R10: Codes 0x7, 0x8, 0xA, 0xC, 0xE and 0xF raise no strobe of any kind: res_we_o, the four flag strobes, neq_o and jump_o all stay low.
- R11: While rst_n is low, all outputs are 0. Outputs reflect the operation issued at the previous clock edge. After an edge with issue_i low, every strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Operation valid this cycle |
| opcode_i | input | 4 | Operation code (high instruction nibble) |
| acc_i | input | W | Accumulator value |
| opnd_i | input | W | Second operand |
| cy_i | input | 1 | Current carry flag |
| res_o | output | W | Result value |
| res_we_o | output | 1 | Result write strobe |
| cy_o | output | 1 | Next carry |
| cy_we_o | output | 1 | Carry update strobe |
| ac_o | output | 1 | Next half carry |
| ac_we_o | output | 1 | Half-carry update strobe |
| ov_o | output | 1 | Next overflow |
| ov_we_o | output | 1 | Overflow update strobe |
| par_o | output | 1 | Next parity |
| par_we_o | output | 1 | Parity update strobe |
| neq_o | output | 1 | Compare found operands unequal |
| jump_o | output | 1 | Loop decrement result is non-zero |

## Verification
The bench builds the unit with W=8. At that width the half carry sits between bits 3 and 4, and integer arithmetic over the 256 values per operand models every carry, borrow and overflow independently of the RTL. That width puts the wrap points 0x00/0xFF and the signed boundary 0x7F/0x80 in direct reach, both from the vector table and from a pseudo-random back-to-back sweep over all sixteen codes.

// File: rtl/alu_acc_pkg.sv
package alu_acc_pkg;

  typedef enum logic [3:0] {
    OPC_INC  = 4'h0,
    OPC_DEC  = 4'h1,
    OPC_ADD  = 4'h2,
    OPC_ADDC = 4'h3,
    OPC_OR   = 4'h4,
    OPC_AND  = 4'h5,
    OPC_XOR  = 4'h6,
    OPC_SUBB = 4'h9,
    OPC_CMP  = 4'hB,
    OPC_LOOP = 4'hD
  } opc_e;

  typedef enum logic [2:0] {
    LOP_PASS = 3'd0,
    LOP_INC  = 3'd1,
    LOP_DEC  = 3'd2,
    LOP_OR   = 3'd3,
    LOP_AND  = 3'd4,
    LOP_XOR  = 3'd5
  } lop_e;

  typedef struct packed {
    logic res_we;   // result is written
    logic arith;    // result comes from adder
    logic sub;      // adder subtracts
    logic cin_en;   // carry input takes part
    lop_e lop;      // non-adder function
    logic c_we;     // carry strobe
    logic flg_we;   // half carry, overflow, parity strobes
    logic cmp;      // compare operation
    logic loop;     // loop decrement
  } ctrl_t;

  localparam int OPC_W = 4;

endpackage

// File: rtl/alu_acc_decode.sv
module alu_acc_decode
  import alu_acc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o
);

  always_comb begin
    ctrl_o = '0;
    ctrl_o.lop = LOP_PASS;
    case (opcode_i)
      OPC_INC:  begin ctrl_o.res_we = 1'b1; ctrl_o.lop = LOP_INC; end
      OPC_DEC:  begin ctrl_o.res_we = 1'b1; ctrl_o.lop = LOP_DEC; end
      OPC_ADD:  begin
        ctrl_o.res_we = 1'b1; ctrl_o.arith = 1'b1;
        ctrl_o.c_we   = 1'b1; ctrl_o.flg_we = 1'b1;
      end
      OPC_ADDC: begin
        ctrl_o.res_we = 1'b1; ctrl_o.arith  = 1'b1; ctrl_o.cin_en = 1'b1;
        ctrl_o.c_we   = 1'b1; ctrl_o.flg_we = 1'b1;
      end
      OPC_OR:   begin ctrl_o.res_we = 1'b1; ctrl_o.lop = LOP_OR;  end
      OPC_AND:  begin ctrl_o.res_we = 1'b1; ctrl_o.lop = LOP_AND; end
      OPC_XOR:  begin ctrl_o.res_we = 1'b1; ctrl_o.lop = LOP_XOR; end
      OPC_SUBB: begin
        ctrl_o.res_we = 1'b1; ctrl_o.arith  = 1'b1; ctrl_o.sub = 1'b1;
        ctrl_o.cin_en = 1'b1; ctrl_o.c_we   = 1'b1; ctrl_o.flg_we = 1'b1;
      end
      OPC_CMP:  begin
        ctrl_o.arith = 1'b1; ctrl_o.sub = 1'b1;
        ctrl_o.c_we  = 1'b1; ctrl_o.cmp = 1'b1;
      end
      OPC_LOOP: begin
        ctrl_o.res_we = 1'b1; ctrl_o.lop = LOP_DEC; ctrl_o.loop = 1'b1;
      end
      default:  ctrl_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_acc_addsub.sv
module alu_acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,   // add: carry in; sub: borrow in
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,     // add: carry out; sub: borrow out
  output logic         ac_o,
  output logic         ov_o
);

  localparam int H  = W / 2;
  localparam int MW = W - H;    // width of middle chunk incl. carry bit

  // Returns {ov, ac, cout, sum}, with carries in the true-adder sense.
  function automatic logic [W+2:0] chunk_add(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic         ci);
    logic [H:0]    lo;
    logic [MW-1:0] mid;
    logic [1:0]    top;
    lo  = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, ci};
    mid = {1'b0, a[W-2:H]} + {1'b0, b[W-2:H]} + {{(MW-1){1'b0}}, lo[H]};
    top = {1'b0, a[W-1]} + {1'b0, b[W-1]} + {1'b0, mid[MW-1]};
    return {top[1] ^ mid[MW-1], lo[H], top[1], top[0], mid[MW-2:0], lo[H-1:0]};
  endfunction

  logic [W-1:0] b_eff;
  logic         ci_eff;
  logic [W+2:0] raw;
  logic         raw_c, raw_ac;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign ci_eff = sub_i ? ~cin_i : cin_i;
  assign raw    = chunk_add(a_i, b_eff, ci_eff);
  assign raw_c  = raw[W];
  assign raw_ac = raw[W+1];

  assign sum_o = raw[W-1:0];
  assign ov_o  = raw[W+2];
  assign c_o   = sub_i ? ~raw_c  : raw_c;
  assign ac_o  = sub_i ? ~raw_ac : raw_ac;

endmodule

// File: rtl/alu_acc_logic.sv
module alu_acc_logic
  import alu_acc_pkg::*;
#(
  parameter int W = 8
) (
  input  lop_e         lop_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    case (lop_i)
      LOP_INC: res_o = opnd_i + W'(1);
      LOP_DEC: res_o = opnd_i - W'(1);
      LOP_OR:  res_o = acc_i | opnd_i;
      LOP_AND: res_o = acc_i & opnd_i;
      LOP_XOR: res_o = acc_i ^ opnd_i;
      default: res_o = opnd_i;
    endcase
  end

endmodule

// File: rtl/alu_acc_core.sv
module alu_acc_core
  import alu_acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [W-1:0]     acc_i,
  input  logic [W-1:0]     opnd_i,
  input  logic             cy_i,
  output logic [W-1:0]     res_o,
  output logic             res_we_o,
  output logic             cy_o,
  output logic             cy_we_o,
  output logic             ac_o,
  output logic             ac_we_o,
  output logic             ov_o,
  output logic             ov_we_o,
  output logic             par_o,
  output logic             par_we_o,
  output logic             neq_o,
  output logic             jump_o
);

  ctrl_t        ctrl;
  logic [W-1:0] as_sum, lg_res, nxt_res;
  logic         as_c, as_ac, as_ov;
  logic         as_cin;
  logic         cmp_ne;      // operands differ
  logic         loop_nz;     // decremented value non-zero
  logic         nxt_par;

  alu_acc_decode u_dec (
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl)
  );

  assign as_cin = ctrl.cin_en & cy_i;

  alu_acc_addsub #(.W(W)) u_as (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (as_cin),
    .sub_i (ctrl.sub),
    .sum_o (as_sum),
    .c_o   (as_c),
    .ac_o  (as_ac),
    .ov_o  (as_ov)
  );

  alu_acc_logic #(.W(W)) u_lg (
    .lop_i  (ctrl.lop),
    .acc_i  (acc_i),
    .opnd_i (opnd_i),
    .res_o  (lg_res)
  );

  assign nxt_res = ctrl.arith ? as_sum : lg_res;
  assign nxt_par = ^nxt_res;
  assign cmp_ne  = (acc_i != opnd_i);
  assign loop_nz = |lg_res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o    <= '0;
      res_we_o <= 1'b0;
      cy_o     <= 1'b0;
      cy_we_o  <= 1'b0;
      ac_o     <= 1'b0;
      ac_we_o  <= 1'b0;
      ov_o     <= 1'b0;
      ov_we_o  <= 1'b0;
      par_o    <= 1'b0;
      par_we_o <= 1'b0;
      neq_o    <= 1'b0;
      jump_o   <= 1'b0;
    end else begin
      res_we_o <= issue_i & ctrl.res_we;
      cy_we_o  <= issue_i & ctrl.c_we;
      ac_we_o  <= issue_i & ctrl.flg_we;
      ov_we_o  <= issue_i & ctrl.flg_we;
      par_we_o <= issue_i & ctrl.flg_we;
      neq_o    <= issue_i & ctrl.cmp & cmp_ne;
      jump_o   <= issue_i & ctrl.loop & loop_nz;
      if (issue_i) begin
        res_o <= nxt_res;
        cy_o  <= as_c;
        ac_o  <= as_ac;
        ov_o  <= as_ov;
        par_o <= nxt_par;
      end
    end
  end

endmodule

// File: rtl/alu_acc_chk.sv
module alu_acc_chk
  import alu_acc_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic [W-1:0]     res_o,
  input logic             res_we_o,
  input logic             cy_we_o,
  input logic             ac_we_o,
  input logic             ov_we_o,
  input logic             par_o,
  input logic             par_we_o,
  input logic             neq_o,
  input logic             jump_o
);

  logic             v_q;
  logic [OPC_W-1:0] op_q;
  logic             any_strobe, flag_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      op_q <= '0;
    end else begin
      v_q  <= issue_i;
      op_q <= opcode_i;
    end
  end

  assign flag_strobe = cy_we_o | ac_we_o | ov_we_o | par_we_o;
  assign any_strobe  = flag_strobe | res_we_o | neq_o | jump_o;

  // R11: nothing strobes after an idle edge
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |-> !any_strobe);

  // R1 R2 R3 R4 R5: arithmetic codes strobe result and all four flags
  a_r1_arith_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (op_q == OPC_ADD || op_q == OPC_ADDC || op_q == OPC_SUBB))
    |-> (res_we_o && cy_we_o && ac_we_o && ov_we_o && par_we_o && !neq_o && !jump_o));

  // R5: parity strobe only with arithmetic, and matches result bits
  a_r5_parity_match: assert property (@(posedge clk) disable iff (!rst_n)
    par_we_o |-> (par_o == ^res_o));

  // R6: increment and decrement leave flags alone
  a_r6_incdec_noflags: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (op_q == OPC_INC || op_q == OPC_DEC)) |-> (res_we_o && !flag_strobe));

  // R7: logic ops leave flags alone
  a_r7_logic_noflags: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (op_q == OPC_OR || op_q == OPC_AND || op_q == OPC_XOR))
    |-> (res_we_o && !flag_strobe));

  // R8: compare touches carry only
  a_r8_cmp_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && op_q == OPC_CMP)
    |-> (cy_we_o && !res_we_o && !ac_we_o && !ov_we_o && !par_we_o && !jump_o));

  // R8: neq only from compare
  a_r8_neq_source: assert property (@(posedge clk) disable iff (!rst_n)
    neq_o |-> (v_q && op_q == OPC_CMP));

  // R9: jump only with a written non-zero result
  a_r9_jump_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |-> (res_we_o && res_o != '0 && !flag_strobe));

  // R10: unused codes are silent
  a_r10_unused_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (op_q == 4'h7 || op_q == 4'h8 || op_q == 4'hA ||
             op_q == 4'hC || op_q == 4'hE || op_q == 4'hF)) |-> !any_strobe);

endmodule

bind alu_acc_core alu_acc_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .issue_i  (issue_i),
  .opcode_i (opcode_i),
  .res_o    (res_o),
  .res_we_o (res_we_o),
  .cy_we_o  (cy_we_o),
  .ac_we_o  (ac_we_o),
  .ov_we_o  (ov_we_o),
  .par_o    (par_o),
  .par_we_o (par_we_o),
  .neq_o    (neq_o),
  .jump_o   (jump_o)
);

// File: tb/alu_acc_core_tb.sv
`timescale 1ns/1ps
module alu_acc_core_tb;

  localparam int W = 8;

  // expected bundle: flag order {c, ac, ov, p}
  typedef struct packed {
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       c;
    logic [7:0] res;
    logic       we;
    logic [3:0] fwe;
    logic [3:0] fl;
    logic       neq;
    logic       jmp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{4'h2, 8'h0F, 8'h01, 1'b0, 8'h10, 1'b1, 4'hF, 4'b0101, 1'b0, 1'b0},
    '{4'h2, 8'h7F, 8'h01, 1'b0, 8'h80, 1'b1, 4'hF, 4'b0111, 1'b0, 1'b0},
    '{4'h2, 8'hFF, 8'h01, 1'b1, 8'h00, 1'b1, 4'hF, 4'b1100, 1'b0, 1'b0},
    '{4'h3, 8'h80, 8'h80, 1'b1, 8'h01, 1'b1, 4'hF, 4'b1011, 1'b0, 1'b0},
    '{4'h3, 8'h3A, 8'h15, 1'b1, 8'h50, 1'b1, 4'hF, 4'b0100, 1'b0, 1'b0},
    '{4'h9, 8'h50, 8'h01, 1'b0, 8'h4F, 1'b1, 4'hF, 4'b0101, 1'b0, 1'b0},
    '{4'h9, 8'h00, 8'h01, 1'b0, 8'hFF, 1'b1, 4'hF, 4'b1100, 1'b0, 1'b0},
    '{4'h9, 8'h80, 8'h01, 1'b0, 8'h7F, 1'b1, 4'hF, 4'b0111, 1'b0, 1'b0},
    '{4'h9, 8'h7F, 8'hFF, 1'b1, 8'h7F, 1'b1, 4'hF, 4'b1101, 1'b0, 1'b0},
    '{4'h0, 8'h12, 8'hFF, 1'b1, 8'h00, 1'b1, 4'h0, 4'b0000, 1'b0, 1'b0},
    '{4'h1, 8'h12, 8'h00, 1'b1, 8'hFF, 1'b1, 4'h0, 4'b0000, 1'b0, 1'b0},
    '{4'h4, 8'hA0, 8'h05, 1'b1, 8'hA5, 1'b1, 4'h0, 4'b0000, 1'b0, 1'b0},
    '{4'h5, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b1, 4'h0, 4'b0000, 1'b0, 1'b0},
    '{4'h6, 8'hFF, 8'h0F, 1'b0, 8'hF0, 1'b1, 4'h0, 4'b0000, 1'b0, 1'b0},
    '{4'hB, 8'h10, 8'h20, 1'b0, 8'h00, 1'b0, 4'h8, 4'b1000, 1'b1, 1'b0},
    '{4'hB, 8'h20, 8'h20, 1'b1, 8'h00, 1'b0, 4'h8, 4'b0000, 1'b0, 1'b0},
    '{4'hB, 8'h30, 8'h20, 1'b1, 8'h00, 1'b0, 4'h8, 4'b0000, 1'b1, 1'b0},
    '{4'hD, 8'h55, 8'h01, 1'b0, 8'h00, 1'b1, 4'h0, 4'b0000, 1'b0, 1'b0},
    '{4'hD, 8'h55, 8'h00, 1'b1, 8'hFF, 1'b1, 4'h0, 4'b0000, 1'b0, 1'b1},
    '{4'h7, 8'h55, 8'h33, 1'b1, 8'h00, 1'b0, 4'h0, 4'b0000, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       issue_i = 1'b0;
  logic [3:0] opcode_i = '0;
  logic [W-1:0] acc_i = '0, opnd_i = '0;
  logic       cy_i = 1'b0;
  logic [W-1:0] res_o;
  logic res_we_o, cy_o, cy_we_o, ac_o, ac_we_o, ov_o, ov_we_o;
  logic par_o, par_we_o, neq_o, jump_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu_acc_core #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .cy_i(cy_i),
    .res_o(res_o), .res_we_o(res_we_o), .cy_o(cy_o), .cy_we_o(cy_we_o),
    .ac_o(ac_o), .ac_we_o(ac_we_o), .ov_o(ov_o), .ov_we_o(ov_we_o),
    .par_o(par_o), .par_we_o(par_we_o), .neq_o(neq_o), .jump_o(jump_o)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h2, 4'h3:       return "R1 R2 R3 R5";
      4'h9:             return "R4 R5";
      4'h0, 4'h1:       return "R6";
      4'h4, 4'h5, 4'h6: return "R7";
      4'hB:             return "R8";
      4'hD:             return "R9";
      default:          return "R10";
    endcase
  endfunction

  // independent integer model
  function automatic vec_t model(input logic [3:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic c);
    vec_t v;
    int ua, ub, uc, sa, sb, r, lo, s;
    v = '0;
    v.op = op; v.a = a; v.b = b; v.c = c;
    ua = int'(a); ub = int'(b); uc = c ? 1 : 0;
    sa = (ua > 127) ? ua - 256 : ua;
    sb = (ub > 127) ? ub - 256 : ub;
    case (op)
      4'h2, 4'h3, 4'h9: begin
        if (op == 4'h2) uc = 0;
        if (op == 4'h9) begin
          r  = ua - ub - uc;
          lo = (ua % 16) - (ub % 16) - uc;
          s  = sa - sb - uc;
          v.fl[3] = (r < 0);
          v.fl[2] = (lo < 0);
        end else begin
          r  = ua + ub + uc;
          lo = (ua % 16) + (ub % 16) + uc;
          s  = sa + sb + uc;
          v.fl[3] = (r > 255);
          v.fl[2] = (lo > 15);
        end
        v.fl[1] = (s > 127) || (s < -128);
        v.res = 8'((r + 512) % 256);
        v.fl[0] = ^v.res;
        v.we = 1'b1; v.fwe = 4'hF;
      end
      4'h0: begin v.res = 8'((ua + 1) % 256); v.we = 1'b1; end
      4'h1, 4'hD: begin
        v.res = 8'((ua * 0 + ub + 255) % 256); v.we = 1'b1;
        v.jmp = (op == 4'hD) && (v.res != 8'h00);
      end
      4'h4: begin v.res = a | b; v.we = 1'b1; end
      4'h5: begin v.res = a & b; v.we = 1'b1; end
      4'h6: begin v.res = a ^ b; v.we = 1'b1; end
      4'hB: begin v.fwe = 4'h8; v.fl[3] = (ua < ub); v.neq = (ua != ub); end
      default: ;
    endcase
    if (op == 4'h0) v.res = 8'((ub + 1) % 256);
    return v;
  endfunction

  task automatic check(input vec_t e, input string tag);
    logic [3:0] gwe, gfl;
    bit bad;
    gwe = {cy_we_o, ac_we_o, ov_we_o, par_we_o};
    gfl = {cy_o, ac_o, ov_o, par_o};
    bad = (res_we_o !== e.we) || (gwe !== e.fwe) || (neq_o !== e.neq) ||
          (jump_o !== e.jmp) || (e.we && (res_o !== e.res)) ||
          (((gfl ^ e.fl) & e.fwe) != 4'h0);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s op=%h a=%h b=%h c=%0d: got res=%h we=%b fwe=%b fl=%b neq=%b jmp=%b exp res=%h we=%b fwe=%b fl=%b neq=%b jmp=%b",
               tag, e.op, e.a, e.b, e.c, res_o, res_we_o, gwe, gfl, neq_o, jump_o,
               e.res, e.we, e.fwe, e.fl, e.neq, e.jmp);
    end
  endtask

  task automatic run(input vec_t e, input bit keep);
    issue_i = 1'b1; opcode_i = e.op; acc_i = e.a; opnd_i = e.b; cy_i = e.c;
    @(negedge clk);
    if (!keep) issue_i = 1'b0;
    check(e, tag_of(e.op));
  endtask

  task automatic check_quiet(input string tag);
    vec_t z;
    z = '0;
    check(z, tag);
  endtask

  initial begin
    logic [31:0] lf;
    vec_t e;
    repeat (3) @(negedge clk);
    // R11: reset state, all outputs zero
    checks++;
    if ({res_o, res_we_o, cy_o, cy_we_o, ac_o, ac_we_o, ov_o, ov_we_o,
         par_o, par_we_o, neq_o, jump_o} !== '0) begin
      fails++;
      $display("FAIL R11 reset: got res=%h strobes=%b exp all 0", res_o,
               {res_we_o, cy_we_o, ac_we_o, ov_we_o, par_we_o, neq_o, jump_o});
    end
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R11 idle after reset");

    // vector table
    for (int i = 0; i < NV; i++) begin
      run(TBL[i], 1'b0);
      @(negedge clk);
      check_quiet("R11 idle after op");
    end

    // R10: every unused code
    foreach (TBL[0].op[k]) ;
    for (int k = 0; k < 16; k++) begin
      if (k inside {7, 8, 10, 12, 14, 15}) begin
        e = model(4'(k), 8'hC3, 8'h3C, 1'b1);
        run(e, 1'b0);
      end
    end

    // back-to-back pseudo-random sweep over all codes
    lf = 32'hACE1_2468;
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      e = model(lf[3:0], lf[11:4], lf[19:12], lf[20]);
      run(e, 1'b1);
    end
    issue_i = 1'b0;
    @(negedge clk);
    check_quiet("R11 idle after burst");

    // reset mid-stream clears everything (R11)
    issue_i = 1'b1; opcode_i = 4'h2; acc_i = 8'hFF; opnd_i = 8'hFF; cy_i = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    issue_i = 1'b0;
    checks++;
    if ({res_o, res_we_o, cy_o, cy_we_o, neq_o, jump_o} !== '0) begin
      fails++;
      $display("FAIL R11 reset over issue: got res=%h we=%b cy=%b exp 0", res_o, res_we_o, cy_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule